// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Mask

This block gathers interrupt requests from a parameterised set of peripheral sources and from two fixed debug sources: a break-condition source and a debug-port source. Each peripheral source has a 4-bit priority that software sets through a small register bus. The block picks the pending request with the highest priority. It forwards that request to the processor only when the priority is strictly above the processor's current 4-bit interrupt mask. It then presents the level the mask must take on acceptance and a vector number that is unique to the source.

Peripheral requests are level inputs. Both debug sources are fixed at level 15. They are captured on a rising edge and stay pending until the processor accepts them. The processor accepts with a one-cycle acknowledge. The vector and level on the outputs during that cycle belong to the accepted request, and the acknowledge clears the latched flag of a winning debug source.

Top module: `intc_prio_top`

## Requirements
- R1: After reset all priority fields read 0, and no request is forwarded even when every peripheral request input is high.
- R2: Priority register word k (bus_addr = k) holds the fields of sources 4k to 4k+3, with source 4k+j in bits [4j+3:4j]. A write takes effect on the clock edge where bus_wr_en is high, and bus_rdata shows the addressed word combinationally. Addresses at or above ceil(NUM_SRC/4) read 0, and writes to them change no register.
- R3: When the winning source is peripheral i with priority p, irq_level equals p and irq_vector equals VEC_BASE+2+i. While irq_req is low, irq_level and irq_vector are 0.
- R4: A request is forwarded (irq_req high) only when its priority is strictly greater than cpu_mask.
- R5: A peripheral source whose priority is 0 is never forwarded.
- R6: Among pending sources, the one with the highest priority wins.
- R7: Ties are resolved by fixed index: break source (index 0), then debug-port source (index 1), then peripheral i (index 2+i), with the lowest index winning.
- R8: A rising edge on brk_req latches a pending break request. It is seen on the outputs from the next cycle with level 15 and vector VEC_BASE, and it stays pending after brk_req falls.
- R9: A rising edge on dbg_req latches a pending debug-port request, with level 15 and vector VEC_BASE+1, held in the same way.
- R10: A debug input that is simply held high raises only one request. No new request appears after it has been accepted until the input falls and rises again.
- R11: irq_ack clears the latched flag of the winning debug source only. The other debug flag stays pending.
- R12: With cpu_mask equal to 15 nothing is forwarded. A pending debug request survives that period and is forwarded once the mask drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Priority word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| periph_req | input | NUM_SRC | Level requests from peripheral sources |
| brk_req | input | 1 | Break-condition request, edge captured |
| dbg_req | input | 1 | Debug-port request, edge captured |
| cpu_mask | input | 4 | Current processor interrupt mask |
| irq_req | output | 1 | Request forwarded to the processor |
| irq_level | output | 4 | Mask level to load on acceptance |
| irq_vector | output | VEC_W | Vector number of the winning source |
| irq_ack | input | 1 | One-cycle acceptance pulse from the processor |

## Verification
Each peripheral source is tried alone at every priority against every mask value. This separates a strict comparison from a non-strict one, shows that level 0 stays silent, and ties each source to its own vector. All request subsets are then applied over a priority pattern with deliberate ties, at two mask values, and the expected winner is computed arithmetically in the bench. This separates highest-priority selection from lowest-index tie breaking. Directed sequences on the two debug inputs cover rise-then-fall holding, simultaneous edges, acknowledge clearing only the winner, a held-high input that must not fire twice, and masking at level 15.

// File: rtl/intc_prio_pkg.sv
package intc_prio_pkg;
  localparam int PRIO_W      = 4;
  localparam int FIELDS_WORD = 4;
  localparam int WORD_W      = PRIO_W * FIELDS_WORD;
  localparam int N_DBG       = 2;
  localparam logic [PRIO_W-1:0] PRIO_MAX = '1;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs
  import intc_prio_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rdata,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  localparam int NUM_WORD = (NUM_SRC + FIELDS_WORD - 1) / FIELDS_WORD;

  logic [WORD_W-1:0] word_q [NUM_WORD];

  for (genvar k = 0; k < NUM_WORD; k++) begin : g_word
    logic [WORD_W-1:0] q, d;
    logic              hit;
    assign hit = wr_en && (addr == ADDR_W'(k));
    always_comb begin
      d = q;
      if (hit) d = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign word_q[k] = q;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_WORD; k++) begin
      if (addr == ADDR_W'(k)) rdata = word_q[k];
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
    assign prio_flat[s*PRIO_W +: PRIO_W] =
      word_q[s / FIELDS_WORD][(s % FIELDS_WORD)*PRIO_W +: PRIO_W];
  end
endmodule

// File: rtl/intc_edge_latch.sv
module intc_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic clr_i,
  output logic pend_o
);
  logic samp_q, pend_q, pend_d, rise;

  assign rise = req_i & ~samp_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (rise)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      samp_q <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_prio_pkg::*;
#(
  parameter int N     = 10,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]        req_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                win_valid,
  output logic [IDX_W-1:0]    win_idx,
  output prio_t               win_lvl
);
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > win_lvl)) begin
        win_lvl = prio_i[i*PRIO_W +: PRIO_W];
        win_idx = IDX_W'(i);
      end
    end
  end
  assign win_valid = (win_lvl != '0);
endmodule

// File: rtl/intc_prio_top.sv
module intc_prio_top
  import intc_prio_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 2,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] periph_req,
  input  logic               brk_req,
  input  logic               dbg_req,
  input  logic [3:0]         cpu_mask,
  output logic               irq_req,
  output logic [3:0]         irq_level,
  output logic [VEC_W-1:0]   irq_vector,
  input  logic               irq_ack
);
  localparam int N_TOT = NUM_SRC + N_DBG;
  localparam int IDX_W = $clog2(N_TOT);

  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [N_DBG-1:0]          dbg_in, dbg_pend, dbg_clr;
  logic [N_TOT-1:0]          all_req;
  logic [N_TOT*PRIO_W-1:0]   all_prio;
  logic                      win_valid;
  logic [IDX_W-1:0]          win_idx;
  prio_t                     win_lvl;
  logic                      fwd;

  intc_prio_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .prio_flat(prio_flat)
  );

  assign dbg_in = {dbg_req, brk_req};

  for (genvar d = 0; d < N_DBG; d++) begin : g_dbg
    assign dbg_clr[d] = irq_ack & fwd & (win_idx == IDX_W'(d));
    intc_edge_latch latch_i (
      .clk(clk), .rst_n(rst_n), .req_i(dbg_in[d]),
      .clr_i(dbg_clr[d]), .pend_o(dbg_pend[d])
    );
    assign all_prio[d*PRIO_W +: PRIO_W] = PRIO_MAX;
  end

  assign all_req = {periph_req, dbg_pend};
  assign all_prio[N_TOT*PRIO_W-1:N_DBG*PRIO_W] = prio_flat;

  intc_arbiter #(.N(N_TOT), .IDX_W(IDX_W)) arb_i (
    .req_i(all_req), .prio_i(all_prio),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign fwd        = win_valid && (win_lvl > cpu_mask);
  assign irq_req    = fwd;
  assign irq_level  = fwd ? win_lvl : '0;
  assign irq_vector = fwd ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : '0;
endmodule

// File: rtl/intc_prio_chk.sv
module intc_prio_chk #(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int NUM_SRC  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             brk_req,
  input logic             irq_ack,
  input logic [3:0]       cpu_mask,
  input logic             irq_req,
  input logic [3:0]       irq_level,
  input logic [VEC_W-1:0] irq_vector
);
  localparam logic [VEC_W-1:0] V_BRK = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] V_TOP = VEC_W'(VEC_BASE + NUM_SRC + 1);

  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > cpu_mask)); // R4

  AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level != 4'd0)); // R5

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector >= V_BRK && irq_vector <= V_TOP)); // R3

  AST_DBG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vector < V_BRK + 2) |-> (irq_level == 4'hF)); // R8

  AST_BRK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |=> (cpu_mask == 4'hF || (irq_req && irq_vector == V_BRK))); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vector == V_BRK && !$rose(brk_req))
      |=> !(irq_req && irq_vector == V_BRK)); // R11
endmodule

bind intc_prio_top intc_prio_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .NUM_SRC(NUM_SRC)) chk_i (.*);

// File: tb/intc_prio_top_tb_top.sv
`timescale 1ns/1ps
module intc_prio_top_tb_top;
  localparam int NS = 8;
  localparam int VB = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr_en = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [NS-1:0] periph_req = 0;
  logic        brk_req = 0, dbg_req = 0, irq_ack = 0;
  logic [3:0]  cpu_mask = 0;
  logic        irq_req;
  logic [3:0]  irq_level;
  logic [7:0]  irq_vector;

  int checks = 0, fails = 0;
  int prio_sh [NS];
  bit done = 0;

  always #2 clk = ~clk;

  intc_prio_top #(.NUM_SRC(NS), .ADDR_W(2), .VEC_W(8), .VEC_BASE(VB)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input int req, input int lvl, input int vec);
    chk(irq_req == req, {tag, " req"}, irq_req, req);
    chk(irq_level == lvl, {tag, " level"}, irq_level, lvl);
    chk(irq_vector == vec, {tag, " vector"}, irq_vector, vec);
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    bus_wr_en = 1; bus_addr = 2'(a); bus_wdata = 16'(d);
    @(posedge clk); #1;
    bus_wr_en = 0;
  endtask

  task automatic set_prio(input int s, input int p);
    int w;
    prio_sh[s] = p;
    w = 0;
    for (int j = 0; j < 4; j++) w |= (prio_sh[(s/4)*4 + j] & 15) << (4*j);
    wr(s/4, w);
  endtask

  task automatic pulse_ack;
    @(negedge clk); irq_ack = 1;
    @(posedge clk); #1 irq_ack = 0;
  endtask

  initial begin
    #(200000*4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ev, el, bl;
    for (int s = 0; s < NS; s++) prio_sh[s] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    periph_req = '1;
    for (int a = 0; a < 2; a++) begin
      bus_addr = 2'(a); @(negedge clk);
      chk(bus_rdata == 0, "R1 prio reset", bus_rdata, 0);
    end
    expect_out("R1 nothing forwarded", 0, 0, 0);
    periph_req = 0;

    // R2 field layout, readback and out-of-range writes
    wr(0, 16'hA5C3); wr(1, 16'h1234); wr(2, 16'hFFFF); wr(3, 16'hFFFF);
    bus_addr = 0; @(negedge clk); chk(bus_rdata == 16'hA5C3, "R2 word0", bus_rdata, 16'hA5C3);
    bus_addr = 1; @(negedge clk); chk(bus_rdata == 16'h1234, "R2 word1", bus_rdata, 16'h1234);
    bus_addr = 2; @(negedge clk); chk(bus_rdata == 0, "R2 out of range", bus_rdata, 0);
    periph_req = 8'h20;             // source 5 sits in word1 bits [7:4] = 3
    @(negedge clk); expect_out("R2 field of src5", 1, 3, VB+2+5);
    periph_req = 0;
    wr(0, 0); wr(1, 0);

    // R3 R4 R5: each source alone, every priority, every mask
    for (int i = 0; i < NS; i++) begin
      for (int p = 0; p < 16; p++) begin
        set_prio(i, p);
        periph_req = NS'(1) << i;
        for (int m = 0; m < 16; m++) begin
          cpu_mask = 4'(m);
          @(negedge clk);
          if (p > m) expect_out("R3 R4 single source", 1, p, VB+2+i);
          else       expect_out("R4 R5 below or at mask", 0, 0, 0);
        end
      end
      set_prio(i, 0);
      periph_req = 0;
    end

    // R6 R7: all subsets over a pattern with ties
    set_prio(0, 3); set_prio(1, 7); set_prio(2, 7); set_prio(3, 0);
    set_prio(4, 12); set_prio(5, 2); set_prio(6, 12); set_prio(7, 5);
    for (int mm = 0; mm < 2; mm++) begin
      cpu_mask = (mm == 0) ? 4'd0 : 4'd6;
      for (int sub = 0; sub < 256; sub++) begin
        periph_req = 8'(sub);
        el = 0; bl = -1;
        for (int s = 0; s < NS; s++)
          if (sub[s] && prio_sh[s] > el) begin el = prio_sh[s]; bl = s; end
        @(negedge clk);
        if (el > cpu_mask) expect_out("R6 R7 subset winner", 1, el, VB+2+bl);
        else               expect_out("R6 R7 subset none", 0, 0, 0);
      end
    end
    periph_req = 0; cpu_mask = 0;

    // R8 break edge, hold after fall, beats a level-15 peripheral
    set_prio(0, 15);
    @(negedge clk); brk_req = 1;
    @(negedge clk); expect_out("R8 break latched", 1, 15, VB);
    brk_req = 0; periph_req = 8'h01;
    @(negedge clk); expect_out("R8 R7 break held, wins tie", 1, 15, VB);
    @(negedge clk); irq_ack = 1;
    chk(irq_vector == VB, "R11 vector during ack", irq_vector, VB);
    @(posedge clk); #1 irq_ack = 0;
    @(negedge clk); expect_out("R11 break cleared", 1, 15, VB+2);
    periph_req = 0;
    @(negedge clk); expect_out("R11 idle", 0, 0, 0);

    // R9 debug-port edge alone
    @(negedge clk); dbg_req = 1;
    @(negedge clk); dbg_req = 0;
    @(negedge clk); expect_out("R9 debug held", 1, 15, VB+1);
    pulse_ack;
    @(negedge clk); expect_out("R9 debug cleared", 0, 0, 0);

    // R7 R11: both edges together
    @(negedge clk); brk_req = 1; dbg_req = 1;
    @(negedge clk); expect_out("R7 break before debug", 1, 15, VB);
    pulse_ack;
    @(negedge clk); expect_out("R11 debug still pending", 1, 15, VB+1);

    // R10: dbg_req held high, accepted once
    pulse_ack;
    repeat (4) @(negedge clk);
    expect_out("R10 held input no refire", 0, 0, 0);
    brk_req = 0; dbg_req = 0;
    @(negedge clk); dbg_req = 1;
    @(negedge clk); expect_out("R10 new rise fires", 1, 15, VB+1);
    pulse_ack; dbg_req = 0;

    // R12 mask 15 blocks, pending survives
    cpu_mask = 4'hF;
    @(negedge clk); brk_req = 1;
    @(negedge clk); brk_req = 0;
    repeat (3) @(negedge clk);
    expect_out("R12 mask 15 blocks", 0, 0, 0);
    cpu_mask = 4'hE;
    @(negedge clk); expect_out("R12 forwarded after mask drop", 1, 15, VB);
    pulse_ack;
    @(negedge clk); expect_out("R12 cleared", 0, 0, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule